// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

A small up-counter whose state bits all change together on the rising clock edge. One parameter selects the counting range: modulo ten (decade) or the full binary range of its state width. A second parameter selects how the active-low clear acts. It can force the state to zero at once, with no clock edge needed. Or it can take effect on the next rising edge, like any other synchronous control.

A synchronous active-low load copies a parallel data word into the state. Load takes priority over counting. Two enables gate counting, and both must be high for the counter to advance. The first enable gates counting only. The second also gates the carry output. The carry is a combinational signal that is high while the second enable is high and the state sits at the last value of the range.

Stages chain into a wider synchronous counter. Each stage's carry feeds the second enable of the next stage, and a common enable drives the first enable of every stage. Feeding a decode of some state back into a synchronous clear shortens the count sequence.

Top module: `sync_preset_counter`

## Requirements
- R1: The state output changes only at a rising edge of `clk`, with all bits at once; input changes between edges leave it unchanged. The one exception is the asynchronous clear of R5.
- R2: With `clr_n` and `load_n` both high, the state advances by one at an edge only when `en_p` and `en_t` are both 1. If either enable is 0, the state holds.
- R3: With `clr_n` high and `load_n` low, the next edge copies `din` into `q`, whatever the levels of `en_p` and `en_t`.
- R4: With `ASYNC_CLR=0`, a low `clr_n` makes `q` equal 0 after the next edge, whatever `load_n`, `en_p` and `en_t` are. Clear wins over load. Before that edge, `q` is unchanged.
- R5: With `ASYNC_CLR=1`, a low `clr_n` forces `q` to 0 at once, with no clock edge, and holds it at 0 while `clr_n` stays low.
- R6: `carry` is combinational. It is 1 exactly when `en_t` is 1 and `q` equals the terminal value: 9 when `DECADE=1`, 15 when `DECADE=0` (width 4).
- R7: When counting, the terminal value steps to 0. For decade that is 9 to 0; for binary it is 15 to 0.
- R8: With `DECADE=1`, the values 10 to 14 step to the next binary value and 15 steps to 0. `carry` stays low at all of these values.
- R9: Three decade stages chain as follows: the common enable drives every `en_p` and the first stage's `en_t`, and each later stage's `en_t` takes the previous stage's `carry`. Chained this way, they count as one integer modulo 1000, with loads and clears applied to all stages.
- R10: With `ASYNC_CLR=0`, driving `clr_n` low whenever `q` equals 5 gives the repeating sequence 0,1,2,3,4,5,0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous as set by `ASYNC_CLR` |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Parallel load data |
| en_p | input | 1 | Count enable that gates counting only |
| en_t | input | 1 | Count enable that gates counting and the carry |
| q | output | WIDTH | Counter state |
| carry | output | 1 | High while `en_t` is 1 and `q` is at the terminal value |

## Verification
The checker treats `clr_n` as the point where its view of the state starts. It checks nothing until the first cycle in which a clear has been seen. It also assumes that a clear, once driven low, stays low through the following rising edge, so a pulse never rises again between edges. The bench drives every input two nanoseconds after a rising edge and holds it for at least one full cycle. The one exception is the asynchronous-clear probe, which lowers `clr_n` in mid-cycle and keeps it low through the next edge. No input ever moves close to an edge.

// File: rtl/spc_pkg.sv
package spc_pkg;
  // Synchronous action chosen for the coming edge (clear is handled in the register)
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } spc_op_e;
endpackage

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
(
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output spc_op_e op
);
  // Load overrides both enables; counting needs both enables
  always_comb begin
    if (!load_n)              op = OP_LOAD;
    else if (en_p && en_t)    op = OP_COUNT;
    else                      op = OP_HOLD;
  end
endmodule

// File: rtl/spc_next.sv
module spc_next
  import spc_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] din,
  input  spc_op_e          op,
  output logic [WIDTH-1:0] d_next
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] incr;

  generate
    if (MODULUS == (1 << WIDTH)) begin : g_binary
      // Full range: natural wrap of the adder
      assign incr = q + 1'b1;
    end else begin : g_modulo
      // Short range: last value returns to zero; out-of-range codes climb to all-ones then wrap
      assign incr = (q == LAST) ? '0 : q + 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_LOAD:  d_next = din;
      OP_COUNT: d_next = incr;
      default:  d_next = q;
    endcase
  end
endmodule

// File: rtl/spc_reg.sv
module spc_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] d_next,
  output logic [WIDTH-1:0] q
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= d_next;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= d_next;
      end
    end
  endgenerate
endmodule

// File: rtl/spc_carry.sv
module spc_carry #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             carry
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);
  assign carry = en_t && (q == LAST);
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import spc_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             carry
);
  localparam int MODULUS = DECADE ? 10 : (1 << WIDTH);

  spc_op_e          op;
  logic [WIDTH-1:0] d_next;

  spc_ctrl u_ctrl (
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  spc_next #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_next (
    .q      (q),
    .din    (din),
    .op     (op),
    .d_next (d_next)
  );

  spc_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk    (clk),
    .clr_n  (clr_n),
    .d_next (d_next),
    .q      (q)
  );

  spc_carry #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_carry (
    .q      (q),
    .en_t   (en_t),
    .carry  (carry)
  );
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] q,
  input logic             carry
);
  localparam int MODULUS = DECADE ? 10 : (1 << WIDTH);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  // State is meaningful once a clear has been observed
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | !clr_n;

  // R4 / R5: a clear seen at an edge leaves zero behind it
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (q == '0));

  // R3: load copies the data regardless of enables
  a_r3_load_copy: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load_n) |=> (!clr_n || q == $past(din)));

  // R2: a missing enable holds the state
  a_r2_hold: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && !(en_p && en_t)) |=> (!clr_n || $stable(q)));

  // R2 / R7: both enables step the state, terminal wraps to zero
  a_r7_wrap: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && en_p && en_t && q == LAST) |=> (!clr_n || q == '0));

  a_r2_step: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && en_p && en_t && q != LAST && q != '1) |=>
      (!clr_n || q == $past(q) + 1'b1));

  // R6: carry needs en_t and the terminal value
  a_r6_carry_gate: assert property (@(posedge clk) disable iff (!armed)
    carry |-> (en_t && q == LAST));

  a_r6_carry_set: assert property (@(posedge clk) disable iff (!armed)
    (en_t && q == LAST) |-> carry);
endmodule

bind sync_preset_counter spc_checker #(
  .WIDTH(WIDTH), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)
) u_spc_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
  .en_p(en_p), .en_t(en_t), .q(q), .carry(carry)
);

// File: tb/sync_preset_counter_bench.sv
`timescale 1ns/1ps
module sync_preset_counter_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // Shared stimulus for the decade/sync-clear and binary/async-clear stages
  logic       clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] qa, qb;
  logic       ca, cb;

  sync_preset_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) u_sync_preset_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(qa), .carry(ca));

  sync_preset_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) u_bin (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(qb), .carry(cb));

  // Three-stage decade cascade
  logic       k_clr_n = 1'b0, k_load_n = 1'b1, k_en = 1'b0;
  logic [3:0] kd0 = 4'd0, kd1 = 4'd0, kd2 = 4'd0;
  logic [3:0] kq0, kq1, kq2;
  logic       kc0, kc1, kc2;

  sync_preset_counter u_cas0 (.clk(clk), .clr_n(k_clr_n), .load_n(k_load_n), .din(kd0),
    .en_p(k_en), .en_t(k_en), .q(kq0), .carry(kc0));
  sync_preset_counter u_cas1 (.clk(clk), .clr_n(k_clr_n), .load_n(k_load_n), .din(kd1),
    .en_p(k_en), .en_t(kc0), .q(kq1), .carry(kc1));
  sync_preset_counter u_cas2 (.clk(clk), .clr_n(k_clr_n), .load_n(k_load_n), .din(kd2),
    .en_p(k_en), .en_t(kc1), .q(kq2), .carry(kc2));

  int n_checks = 0, n_fail = 0;
  int ref_a = 0, ref_b = 0, ref_k = 0;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int q, input int modu);
    int n;
    if (!clr_n) return 0;
    if (!load_n) return int'(din);
    if (!(en_p && en_t)) return q;
    n = (q == modu - 1) ? 0 : q + 1;
    return n & 15;
  endfunction

  // One edge for the single stages; inputs move 2 ns after the edge
  task automatic tick();
    int na, nb;
    na = model(ref_a, 10);
    nb = model(ref_b, 16);
    @(posedge clk); #2;
    ref_a = na; ref_b = nb;
  endtask

  task automatic check_pair(input string req);
    check({req, " decade q"}, int'(qa), ref_a);
    check({req, " binary q"}, int'(qb), ref_b);
  endtask

  task automatic set_in(input logic c, input logic l, input logic [3:0] d,
                        input logic p, input logic t);
    clr_n = c; load_n = l; din = d; en_p = p; en_t = t;
  endtask

  task automatic t_reset();
    set_in(1'b0, 1'b0, 4'd6, 1'b1, 1'b1);
    tick();
    check_pair("R4 R5 clear beats load");
    check("R4 value", int'(qa), 0);
  endtask

  task automatic t_count();
    set_in(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin tick(); check_pair("R2 count"); end
    check("R2 count reaches 4", int'(qa), 4);
    en_p = 1'b0; tick(); check_pair("R2 hold p low");
    check("R2 held at 4", int'(qb), 4);
    en_p = 1'b1; en_t = 1'b0; tick(); check_pair("R2 hold t low");
    en_t = 1'b1; tick(); check("R2 resumes", int'(qa), 5);
  endtask

  task automatic t_load();
    set_in(1'b1, 1'b0, 4'd7, 1'b1, 1'b1); tick(); check_pair("R3 load with enables");
    check("R3 loaded 7", int'(qa), 7);
    set_in(1'b1, 1'b0, 4'd2, 1'b0, 1'b0); tick(); check_pair("R3 load no enables");
    check("R3 loaded 2", int'(qb), 2);
  endtask

  task automatic t_edge_only();
    set_in(1'b1, 1'b1, 4'd0, 1'b0, 1'b0); tick();
    load_n = 1'b0; din = 4'd11; en_p = 1'b1; en_t = 1'b1; #3;
    check("R1 no change before edge decade", int'(qa), ref_a);
    check("R1 no change before edge binary", int'(qb), ref_b);
    load_n = 1'b1; en_p = 1'b0;
    tick(); check_pair("R1 after edge");
  endtask

  task automatic t_async();
    set_in(1'b1, 1'b0, 4'd5, 1'b0, 1'b0); tick();
    clr_n = 1'b0; #1;
    check("R5 async clear immediate", int'(qb), 0);
    check("R4 sync clear waits", int'(qa), 5);
    tick(); check_pair("R4 sync clear after edge");
  endtask

  task automatic t_carry();
    set_in(1'b1, 1'b0, 4'd9, 1'b0, 1'b0); tick();
    load_n = 1'b1; #1;
    check("R6 carry t low", int'(ca), 0);
    en_t = 1'b1; #1;
    check("R6 carry decade at 9", int'(ca), 1);
    check("R6 binary no carry at 9", int'(cb), 0);
    load_n = 1'b0; din = 4'd15; tick(); load_n = 1'b1; #1;
    check("R6 binary carry at 15", int'(cb), 1);
    check("R8 decade no carry at 15", int'(ca), 0);
    en_t = 1'b0; #1;
    check("R6 binary carry gated", int'(cb), 0);
  endtask

  task automatic t_wrap();
    set_in(1'b1, 1'b0, 4'd9, 1'b1, 1'b1); tick();
    load_n = 1'b1; tick();
    check("R7 decade 9 to 0", int'(qa), 0);
    check("R7 binary 9 to 10", int'(qb), 10);
    load_n = 1'b0; din = 4'd15; tick(); load_n = 1'b1; tick();
    check("R7 binary 15 to 0", int'(qb), 0);
    check("R8 decade 15 to 0", int'(qa), 0);
    load_n = 1'b0; din = 4'd12; tick(); load_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1; check("R8 no carry out of range", int'(ca), 0);
      tick(); check_pair("R8 out-of-range climb");
    end
    check("R8 ends at 0", int'(qa), 0);
  endtask

  task automatic t_shorten();
    set_in(1'b0, 1'b1, 4'd0, 1'b1, 1'b1); tick();
    clr_n = 1'b1;
    for (int i = 0; i < 13; i++) begin
      clr_n = (qa == 4'd5) ? 1'b0 : 1'b1;
      tick();
      check("R10 shortened sequence", int'(qa), (i + 1) % 6);
    end
  endtask

  task automatic t_cascade();
    en_p = 1'b0; en_t = 1'b0; clr_n = 1'b1;
    k_clr_n = 1'b0; @(posedge clk); #2; ref_k = 0;
    for (int i = 0; i < 420; i++) begin
      int nk, lv;
      k_clr_n = ($urandom_range(0, 29) != 0);
      k_load_n = ($urandom_range(0, 19) != 0);
      k_en = (i < 120) ? 1'b1 : ($urandom_range(0, 3) != 0);
      lv = (i == 5) ? 990 : int'($urandom_range(0, 999));
      if (i == 5) begin k_clr_n = 1'b1; k_load_n = 1'b0; end
      kd0 = 4'(lv % 10); kd1 = 4'((lv / 10) % 10); kd2 = 4'(lv / 100);
      if (!k_clr_n) nk = 0;
      else if (!k_load_n) nk = lv;
      else if (k_en) nk = (ref_k + 1) % 1000;
      else nk = ref_k;
      @(posedge clk); #2;
      ref_k = nk;
      check("R9 cascade value", int'(kq2) * 100 + int'(kq1) * 10 + int'(kq0), ref_k);
    end
  endtask

  bit done = 1'b0;
  initial begin
    t_reset();
    t_count();
    t_load();
    t_edge_only();
    t_async();
    t_carry();
    t_wrap();
    t_shorten();
    t_cascade();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule